// File: doc/BRIEF.md
# Ten-Bit Serializer with Post-Cursor Tap

This block turns a ten-bit parallel word into a serial stream for a transmitter with two-tap pre-emphasis. One word is taken in per word period, and ten bits leave per word period, one on each cycle of the full-rate bit clock.

The word is split into two five-bit lanes. One lane holds the even-indexed bits and the other holds the odd-indexed bits. Each lane shifts toward its head once every two bit cycles. A phase flag chooses which lane head drives the serial output: the even lane on the even phase and the odd lane on the odd phase. This is the two-edge half-rate interleave, modelled with a single full-rate clock. So each lane runs at half the bit rate, and only the final selection runs at the full rate.

A second register, in step with the bit clock, gives the post-cursor tap. That tap is the inverse of the main bit of the previous cycle. A load strobe, raised every ten bit cycles by the word-clock logic, captures the next word. The first bit of that word then follows the last bit of the previous word with no gap.

Top module: `pe_serializer`

## Requirements
- R1: While `rst` is high at a rising clock edge, after that edge `main_bit` is 0 and `post_bit` is 1.
- R2: In the cycle after an edge at which `load` is high, `main_bit` equals bit 0 of the `word_in` value captured at that edge.
- R3: With no further load, the next nine cycles show bits 1 through 9 of the captured word, in ascending index order, so the serial stream rebuilds the word exactly.
- R4: Raising `load` every ten cycles gives a continuous stream: bit 0 of a new word follows bit 9 of the previous word in the very next cycle, for every possible 10-bit word.
- R5: After every edge with `rst` low, `post_bit` equals the inverse of the `main_bit` value shown in the cycle before that edge.
- R6: A load raised before all ten bits have been sent drops the rest of the current word and starts the new word at its bit 0.
- R7: When the ten bits of a word have been sent and no new load has come, `main_bit` stays 0 until the next load.
- R8: The phase flag alternates on every edge that is not a load edge, and a load edge returns it to the even-lane phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Full-rate bit clock |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Word-capture strobe, one cycle per word |
| word_in | input | 10 | Parallel word; bit 0 is sent first |
| main_bit | output | 1 | Main-tap serial bit |
| post_bit | output | 1 | Post-cursor tap: inverse of the previous main bit |

## Verification
The assertions check on every cycle these behaviours: the inverted one-bit delay of the post tap, the arrival of bit 0 and bit 1 right after a load, the alternation of the phase flag, and a quiet output once a word has drained. They also check the reset values. Only the bench scenarios can show the full ordering of all ten bits and the gap-free joins between words. The bench covers every 10-bit code sent back to back, early reloads that cut a word short, and idle periods after a word.

// File: rtl/pe_ser_pkg.sv
package pe_ser_pkg;

    localparam int unsigned WORD_W_DEF = 10;
    localparam int unsigned LANE_CNT   = 2;

    typedef enum logic {
        PH_EVEN = 1'b0,
        PH_ODD  = 1'b1
    } phase_e;

    typedef struct packed {
        logic odd_head;
        logic even_head;
    } lane_heads_t;

    function automatic int unsigned lane_depth(input int unsigned word_w);
        return word_w / LANE_CNT;
    endfunction

    function automatic phase_e next_phase(input phase_e cur, input logic restart);
        if (restart) begin
            return PH_EVEN;
        end
        return (cur == PH_EVEN) ? PH_ODD : PH_EVEN;
    endfunction

endpackage

// File: rtl/ser_lane.sv
module ser_lane #(
    parameter int unsigned WORD_W = 10,
    parameter int unsigned LANE   = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              advance,
    input  logic [WORD_W-1:0] word_in,
    output logic              head
);
    localparam int unsigned DEPTH = pe_ser_pkg::lane_depth(WORD_W);

    logic [DEPTH-1:0] sr_q;
    logic [DEPTH-1:0] pick;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            pick[i] = word_in[pe_ser_pkg::LANE_CNT * i + LANE];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q <= '0;
        end else if (load) begin
            sr_q <= pick;
        end else if (advance) begin
            sr_q <= {1'b0, sr_q[DEPTH-1:1]};
        end
    end

    assign head = sr_q[0];

endmodule

// File: rtl/ser_interleave.sv
module ser_interleave
    import pe_ser_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        load,
    input  lane_heads_t heads,
    output phase_e      phase,
    output logic        serial_out
);
    phase_e phase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_EVEN;
        end else begin
            phase_q <= next_phase(phase_q, load);
        end
    end

    assign phase      = phase_q;
    assign serial_out = (phase_q == PH_ODD) ? heads.odd_head : heads.even_head;

endmodule

// File: rtl/ser_post_tap.sv
module ser_post_tap (
    input  logic clk,
    input  logic rst,
    input  logic main_bit,
    output logic post_bit
);
    always_ff @(posedge clk) begin
        if (rst) begin
            post_bit <= 1'b1;
        end else begin
            post_bit <= ~main_bit;
        end
    end

endmodule

// File: rtl/pe_serializer.sv
module pe_serializer
    import pe_ser_pkg::*;
#(
    parameter int unsigned WORD_W = WORD_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] word_in,
    output logic              main_bit,
    output logic              post_bit
);
    phase_e            phase_q;
    lane_heads_t       heads;
    logic [LANE_CNT-1:0] lane_head;
    logic [LANE_CNT-1:0] lane_adv;

    generate
        for (genvar l = 0; l < LANE_CNT; l++) begin : g_lane
            assign lane_adv[l] = (phase_q == phase_e'(l));
            ser_lane #(
                .WORD_W (WORD_W),
                .LANE   (l)
            ) u_lane (
                .clk     (clk),
                .rst     (rst),
                .load    (load),
                .advance (lane_adv[l]),
                .word_in (word_in),
                .head    (lane_head[l])
            );
        end
    endgenerate

    assign heads.even_head = lane_head[0];
    assign heads.odd_head  = lane_head[1];

    ser_interleave u_mux (
        .clk        (clk),
        .rst        (rst),
        .load       (load),
        .heads      (heads),
        .phase      (phase_q),
        .serial_out (main_bit)
    );

    ser_post_tap u_post (
        .clk      (clk),
        .rst      (rst),
        .main_bit (main_bit),
        .post_bit (post_bit)
    );

endmodule

// File: rtl/pe_serializer_chk.sv
module pe_serializer_chk
    import pe_ser_pkg::*;
#(
    parameter int unsigned WORD_W = WORD_W_DEF
) (
    input logic       clk,
    input logic       rst,
    input logic       load,
    input logic [1:0] word_lo,
    input logic       main_bit,
    input logic       post_bit,
    input phase_e     phase
);
    localparam int unsigned CNT_W = $clog2(WORD_W + 2);
    localparam logic [CNT_W-1:0] IDLE_MARK = CNT_W'(WORD_W + 1);

    logic [CNT_W-1:0] since_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_q <= IDLE_MARK;
        end else if (load) begin
            since_q <= CNT_W'(1);
        end else if (since_q != IDLE_MARK) begin
            since_q <= since_q + CNT_W'(1);
        end
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (!main_bit && post_bit));

    // R2
    first_bit_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (main_bit == $past(word_lo[0])));

    // R3
    second_bit_chk: assert property (@(posedge clk) disable iff (rst)
        load ##1 !load |=> (main_bit == $past(word_lo[1], 2)));

    // R5
    post_tap_chk: assert property (@(posedge clk) disable iff (rst)
        post_bit == ~$past(main_bit));

    // R7
    drained_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (since_q == IDLE_MARK) |-> !main_bit);

    // R8
    phase_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> (phase != $past(phase)));

    // R8
    phase_restart_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (phase == PH_EVEN));

endmodule

bind pe_serializer pe_serializer_chk #(.WORD_W(WORD_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .word_lo  (word_in[1:0]),
    .main_bit (main_bit),
    .post_bit (post_bit),
    .phase    (phase_q)
);

// File: tb/pe_serializer_test.sv
module pe_serializer_test;
    localparam int unsigned W = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         load = 1'b0;
    logic [W-1:0] word_in = '0;
    logic         main_bit;
    logic         post_bit;

    int checks = 0;
    int errors = 0;

    logic [W-1:0] cur_word = '0;
    int           idx = W;
    logic         exp_main = 1'b0;
    logic         prev_exp = 1'b0;
    logic [W-1:0] rebuilt;

    always #10 clk = ~clk;

    pe_serializer uut (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .word_in  (word_in),
        .main_bit (main_bit),
        .post_bit (post_bit)
    );

    task automatic check_bit(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    // one bit cycle: drive, let the edge pass, update model, sample at negedge
    task automatic step(input logic ld, input logic [W-1:0] w, input string tag);
        load    = ld;
        word_in = w;
        @(posedge clk);
        prev_exp = exp_main;
        if (ld) begin
            cur_word = w;
            idx = 0;
        end else if (idx < W) begin
            idx++;
        end
        exp_main = (idx < W) ? cur_word[idx] : 1'b0;
        @(negedge clk);
        check_bit((ld ? "R2 first bit" : tag), main_bit, exp_main);
        check_bit("R5 post tap", post_bit, ~prev_exp);
        if (idx < W) rebuilt[idx] = main_bit;
    endtask

    task automatic send_word(input logic [W-1:0] w, input string tag);
        rebuilt = '0;
        step(1'b1, w, tag);
        for (int b = 1; b < W; b++) begin
            step(1'b0, '0, tag);
        end
        checks++;
        if (rebuilt !== w) begin
            errors++;
            $display("FAIL R3 rebuilt word: actual %h expected %h", rebuilt, w);
        end
    endtask

    task automatic do_reset();
        rst  = 1'b1;
        load = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        check_bit("R1 reset main", main_bit, 1'b0);
        check_bit("R1 reset post", post_bit, 1'b1);
        rst = 1'b0;
        idx = W;
        exp_main = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        // idle after reset: output stays quiet
        for (int k = 0; k < 4; k++) step(1'b0, '0, "R7 idle after reset");

        // fixed patterns
        send_word(10'b0000011111, "R3 low half ones");
        send_word(10'b0101010101, "R3 alternating");
        send_word(10'b1010101010, "R3 alternating inverse");
        send_word(10'b1111111111, "R3 all ones");
        send_word(10'b0000000000, "R3 all zeros");
        send_word(10'b1000000001, "R3 edge bits");

        // drain: no load after the word
        send_word(10'b1111111111, "R3 before drain");
        for (int k = 0; k < 6; k++) step(1'b0, '0, "R7 drained");

        // early reload cuts the word short
        step(1'b1, 10'b1111111111, "R6 first");
        step(1'b0, '0, "R6 partial");
        step(1'b0, '0, "R6 partial");
        send_word(10'b0000000010, "R6 restart");

        // exhaustive back-to-back sweep
        for (int v = 0; v < (1 << W); v++) begin
            send_word(W'(v), "R4 continuous sweep");
        end

        // random words with gaps
        for (int n = 0; n < 200; n++) begin
            send_word(W'($urandom), "R3 random");
            if (n % 7 == 0) step(1'b0, '0, "R7 gap");
        end

        // reset in mid-word
        step(1'b1, 10'b1111111111, "R2 before reset");
        step(1'b0, '0, "R3 before reset");
        do_reset();
        step(1'b0, '0, "R7 after mid reset");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule